// File: doc/BRIEF.md
# Processor Status Flags and Conditional Branch Resolver

This block holds the six live condition and mode flags of an 8-bit processor: negative, overflow, decimal, interrupt-disable, zero and carry. Every cycle it can take a masked write of flag values from the arithmetic unit. It can also take a one-flag set or clear command, decoded from the current instruction opcode, and a full-byte restore from data pulled off the stack. It always presents the status as a byte that can be pushed to the stack.

The same opcode input is also tested as a conditional branch. The block decodes which flag the branch tests, and whether the branch wants that flag set or clear, directly from the opcode bit pattern. The branch-taken result is combinational from the flags held now, so the sequencer can use it in the same cycle that it presents the branch opcode. Target address arithmetic, stack memory traffic and interrupt sequencing belong to other blocks.

Top module: `psr_branch_unit`

## Requirements
- R1: A clock edge with `rst` high leaves the interrupt-disable flag set and every other flag clear, so `status_byte` reads 24h (with `op_valid` low).
- R2: At a clock edge, each flag whose `alu_mask` bit is 1 takes the value of the matching `alu_flags` bit. The bit positions are N=7, V=6, D=3, I=2, Z=1, C=0. Mask bits 5 and 4 have no effect. Flags whose mask bit is 0 keep their value.
- R3: With `op_valid` high, opcode 18h clears C, D8h clears D, 58h clears I and B8h clears V at the next edge.
- R4: With `op_valid` high, opcode 38h sets C, F8h sets D, and both 78h and 00h set I at the next edge. No opcode sets V.
- R5: When a set or clear command and a masked ALU write target the same flag in one cycle, the command decides that flag. ALU writes to the other flags still take effect.
- R6: With `restore_en` high, all six flags load from `restore_byte` at the bit positions of R2, overriding ALU writes and commands. Input bits 5 and 4 are ignored.
- R7: `status_byte` bit 5 always reads 1. Bit 4 reads 1 only while `op_valid` is high with opcode 08h or 00h, and 0 otherwise. Opcode 08h changes no flag.
- R8: With `op_valid` high, `branch_taken` is high in the same cycle when the opcode's test holds on the current flags: B0h C=1, 90h C=0, F0h Z=1, D0h Z=0, 30h N=1, 10h N=0, 70h V=1, 50h V=0.
- R9: `branch_taken` is low for every opcode that is not one of the eight branch opcodes, and whenever `op_valid` is low.
- R10: While `op_valid` is low, `op_code` changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_flags | input | 8 | Flag values from the arithmetic unit, in status-byte positions |
| alu_mask | input | 8 | Per-flag write enable for `alu_flags` |
| op_valid | input | 1 | `op_code` holds a current instruction |
| op_code | input | 8 | Instruction opcode, used for flag commands and branch tests |
| restore_en | input | 1 | Load all flags from `restore_byte` |
| restore_byte | input | 8 | Status byte pulled from the stack |
| status_byte | output | 8 | Current status for pushing to the stack |
| branch_taken | output | 1 | The branch opcode's condition holds |

## Verification
The embedded properties assume that the command decoder never asks to set and clear the same flag for one opcode. They also assume that a restore, when present, is the only source that matters for the next flag value. Given those, the properties check the priority between restore, command and masked ALU write on the registered flags. The bench changes every input only at falling edges and holds reset high for several rising edges before any other stimulus. It reads combinational results such as the break bit and `branch_taken` just after a falling edge, and registered flags one falling edge after the rising edge that loads them.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int BYTE_W = 8;

    // Bit positions inside the status byte
    localparam int POS_N   = 7;
    localparam int POS_V   = 6;
    localparam int POS_ONE = 5;
    localparam int POS_BRK = 4;
    localparam int POS_D   = 3;
    localparam int POS_I   = 2;
    localparam int POS_Z   = 1;
    localparam int POS_C   = 0;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } psr_flags_t;

    localparam psr_flags_t FLAGS_RESET = '{n: 1'b0, v: 1'b0, d: 1'b0, i: 1'b1, z: 1'b0, c: 1'b0};

    // Flag-command opcodes
    localparam logic [BYTE_W-1:0] OPC_CLR_C  = 8'h18;
    localparam logic [BYTE_W-1:0] OPC_CLR_D  = 8'hD8;
    localparam logic [BYTE_W-1:0] OPC_CLR_I  = 8'h58;
    localparam logic [BYTE_W-1:0] OPC_CLR_V  = 8'hB8;
    localparam logic [BYTE_W-1:0] OPC_SET_C  = 8'h38;
    localparam logic [BYTE_W-1:0] OPC_SET_D  = 8'hF8;
    localparam logic [BYTE_W-1:0] OPC_SET_I  = 8'h78;
    localparam logic [BYTE_W-1:0] OPC_SWI    = 8'h00;
    localparam logic [BYTE_W-1:0] OPC_PUSH_P = 8'h08;

    // Branch condition selector, taken from opcode bits 7:6
    typedef enum logic [1:0] {
        BSEL_N = 2'b00,
        BSEL_V = 2'b01,
        BSEL_C = 2'b10,
        BSEL_Z = 2'b11
    } br_sel_e;

    function automatic psr_flags_t byte_to_flags(input logic [BYTE_W-1:0] b);
        psr_flags_t f;
        f.n = b[POS_N];
        f.v = b[POS_V];
        f.d = b[POS_D];
        f.i = b[POS_I];
        f.z = b[POS_Z];
        f.c = b[POS_C];
        return f;
    endfunction

    function automatic logic [BYTE_W-1:0] flags_to_byte(input psr_flags_t f, input logic brk);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[POS_N]   = f.n;
        b[POS_V]   = f.v;
        b[POS_ONE] = 1'b1;
        b[POS_BRK] = brk;
        b[POS_D]   = f.d;
        b[POS_I]   = f.i;
        b[POS_Z]   = f.z;
        b[POS_C]   = f.c;
        return b;
    endfunction

endpackage

// File: rtl/psr_cmd_decode.sv
module psr_cmd_decode
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [BYTE_W-1:0] op_code,
    output psr_flags_t        set_mask,
    output psr_flags_t        clr_mask,
    output logic              push_brk
);

    always_comb begin
        set_mask = '0;
        clr_mask = '0;
        push_brk = 1'b0;
        if (op_valid) begin
            unique case (op_code)
                OPC_CLR_C:  clr_mask.c = 1'b1;
                OPC_CLR_D:  clr_mask.d = 1'b1;
                OPC_CLR_I:  clr_mask.i = 1'b1;
                OPC_CLR_V:  clr_mask.v = 1'b1;
                OPC_SET_C:  set_mask.c = 1'b1;
                OPC_SET_D:  set_mask.d = 1'b1;
                OPC_SET_I:  set_mask.i = 1'b1;
                OPC_SWI: begin
                    set_mask.i = 1'b1;
                    push_brk   = 1'b1;
                end
                OPC_PUSH_P: push_brk = 1'b1;
                default: ;
            endcase
        end
    end

    // R10: no command leaves the decoder without a valid opcode
    a_r10_idle_no_cmd: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> (set_mask == '0) && (clr_mask == '0) && !push_brk);

    // R3 / R4: at most one flag is commanded, never both ways
    a_r3_single_cmd: assert property (@(posedge clk) disable iff (rst)
        $onehot0({set_mask, clr_mask}));

    // R4: overflow is never set by command
    a_r4_no_set_v: assert property (@(posedge clk) disable iff (rst)
        !set_mask.v);

endmodule

// File: rtl/psr_flag_reg.sv
module psr_flag_reg
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] alu_flags,
    input  logic [BYTE_W-1:0] alu_mask,
    input  psr_flags_t        set_mask,
    input  psr_flags_t        clr_mask,
    input  logic              restore_en,
    input  logic [BYTE_W-1:0] restore_byte,
    output psr_flags_t        flags
);

    psr_flags_t alu_sel;
    psr_flags_t alu_val;
    psr_flags_t after_alu;
    psr_flags_t after_cmd;
    psr_flags_t flags_nxt;

    always_comb begin
        alu_sel   = byte_to_flags(alu_mask);
        alu_val   = byte_to_flags(alu_flags);
        after_alu = (flags & ~alu_sel) | (alu_val & alu_sel);
        after_cmd = (after_alu & ~clr_mask) | set_mask;
        flags_nxt = restore_en ? byte_to_flags(restore_byte) : after_cmd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= FLAGS_RESET;
        end else begin
            flags <= flags_nxt;
        end
    end

    // R6: restore loads every flag from the pulled byte
    a_r6_restore_load: assert property (@(posedge clk) disable iff (rst)
        restore_en |=> (flags == byte_to_flags($past(restore_byte))));

    // R5: a clear command beats the ALU write
    a_r5_clear_wins: assert property (@(posedge clk) disable iff (rst)
        !restore_en |=> ((flags & $past(clr_mask)) == '0));

    // R5: a set command beats the ALU write
    a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
        !restore_en |=> ((flags & $past(set_mask)) == $past(set_mask)));

    // R2: unmasked, uncommanded flags hold their value
    a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (rst)
        (!restore_en && set_mask == '0 && clr_mask == '0) |=>
        ((flags & ~$past(alu_sel)) == ($past(flags) & ~$past(alu_sel))));

endmodule

// File: rtl/psr_branch_eval.sv
module psr_branch_eval
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [BYTE_W-1:0] op_code,
    input  psr_flags_t        flags,
    output logic              taken
);

    localparam int SEL_HI   = BYTE_W - 1;
    localparam int SEL_LO   = BYTE_W - 2;
    localparam int POL_BIT  = BYTE_W - 3;
    localparam int MARK_BIT = BYTE_W - 4;
    localparam int LOW_W    = BYTE_W - 4;

    br_sel_e sel;
    logic    is_branch;
    logic    tested;

    always_comb begin
        sel       = br_sel_e'(op_code[SEL_HI:SEL_LO]);
        is_branch = op_valid && op_code[MARK_BIT] && (op_code[LOW_W-1:0] == '0);
        unique case (sel)
            BSEL_N:  tested = flags.n;
            BSEL_V:  tested = flags.v;
            BSEL_C:  tested = flags.c;
            default: tested = flags.z;
        endcase
        taken = is_branch && (tested == op_code[POL_BIT]);
    end

    // R9: never taken without a valid opcode
    a_r9_idle_not_taken: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !taken);

    // R8 / R9: taken only for a branch-shaped opcode
    a_r8_shape: assert property (@(posedge clk) disable iff (rst)
        taken |-> (op_code[LOW_W-1:0] == '0) && op_code[MARK_BIT]);

endmodule

// File: rtl/psr_branch_unit.sv
module psr_branch_unit
    import psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] alu_flags,
    input  logic [BYTE_W-1:0] alu_mask,
    input  logic              op_valid,
    input  logic [BYTE_W-1:0] op_code,
    input  logic              restore_en,
    input  logic [BYTE_W-1:0] restore_byte,
    output logic [BYTE_W-1:0] status_byte,
    output logic              branch_taken
);

    psr_flags_t set_mask;
    psr_flags_t clr_mask;
    psr_flags_t flags;
    logic       push_brk;

    psr_cmd_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_code  (op_code),
        .set_mask (set_mask),
        .clr_mask (clr_mask),
        .push_brk (push_brk)
    );

    psr_flag_reg u_flags (
        .clk          (clk),
        .rst          (rst),
        .alu_flags    (alu_flags),
        .alu_mask     (alu_mask),
        .set_mask     (set_mask),
        .clr_mask     (clr_mask),
        .restore_en   (restore_en),
        .restore_byte (restore_byte),
        .flags        (flags)
    );

    psr_branch_eval u_branch (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_code  (op_code),
        .flags    (flags),
        .taken    (branch_taken)
    );

    assign status_byte = flags_to_byte(flags, push_brk);

    // R7: the constant-one position never drops
    a_r7_bit5_high: assert property (@(posedge clk) disable iff (rst)
        status_byte[POS_ONE]);

    // R7: break bit only shows during a push-type opcode
    a_r7_brk_gated: assert property (@(posedge clk) disable iff (rst)
        status_byte[POS_BRK] |-> op_valid);

endmodule

// File: tb/test_psr_branch_unit.sv
module test_psr_branch_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] alu_flags = '0;
    logic [7:0] alu_mask = '0;
    logic       op_valid = 1'b0;
    logic [7:0] op_code = '0;
    logic       restore_en = 1'b0;
    logic [7:0] restore_byte = '0;
    logic [7:0] status_byte;
    logic       branch_taken;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    psr_branch_unit i_psr_branch_unit (
        .clk          (clk),
        .rst          (rst),
        .alu_flags    (alu_flags),
        .alu_mask     (alu_mask),
        .op_valid     (op_valid),
        .op_code      (op_code),
        .restore_en   (restore_en),
        .restore_byte (restore_byte),
        .status_byte  (status_byte),
        .branch_taken (branch_taken)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic idle();
        alu_flags = '0; alu_mask = '0; op_valid = 1'b0; op_code = '0;
        restore_en = 1'b0; restore_byte = '0;
    endtask

    // Drive one cycle of inputs, then idle and settle past the load edge
    task automatic cycle(input logic [7:0] af, input logic [7:0] am, input logic v,
                         input logic [7:0] op, input logic ren, input logic [7:0] rb);
        @(negedge clk);
        alu_flags = af; alu_mask = am; op_valid = v; op_code = op;
        restore_en = ren; restore_byte = rb;
        @(negedge clk);
        idle();
        #1;
    endtask

    task automatic load(input logic [7:0] b);
        cycle(8'h00, 8'h00, 1'b0, 8'h00, 1'b1, b);
    endtask

    function automatic logic exp_branch(input logic [7:0] op, input logic [7:0] s);
        case (op)
            8'hB0: return s[0];
            8'h90: return !s[0];
            8'hF0: return s[1];
            8'hD0: return !s[1];
            8'h30: return s[7];
            8'h10: return !s[7];
            8'h70: return s[6];
            8'h50: return !s[6];
            default: return 1'b0;
        endcase
    endfunction

    task automatic t_reset();
        chk("R1 reset status", status_byte, 8'h24);
        chk("R1 reset branch", {7'b0, branch_taken}, 8'h00);
    endtask

    task automatic t_alu();
        cycle(8'hFF, 8'h82, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R2 masked N,Z", status_byte, 8'hA6);
        cycle(8'h00, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R2 all clear", status_byte, 8'h20);
        cycle(8'hFF, 8'hFF, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R2 all set, bits 5/4 ignored", status_byte, 8'hEF);
        cycle(8'h00, 8'h30, 1'b0, 8'h00, 1'b0, 8'h00);
        chk("R2 mask bits 5/4 no effect", status_byte, 8'hEF);
    endtask

    task automatic t_cmds();
        load(8'hEF);
        cycle(8'h00, 8'h00, 1'b0, 8'h18, 1'b0, 8'h00);
        chk("R10 invalid op ignored", status_byte, 8'hEF);
        cycle(8'h00, 8'h00, 1'b1, 8'h18, 1'b0, 8'h00);
        chk("R3 clear C", status_byte, 8'hEE);
        cycle(8'h00, 8'h00, 1'b1, 8'hD8, 1'b0, 8'h00);
        chk("R3 clear D", status_byte, 8'hE6);
        cycle(8'h00, 8'h00, 1'b1, 8'h58, 1'b0, 8'h00);
        chk("R3 clear I", status_byte, 8'hE2);
        cycle(8'h00, 8'h00, 1'b1, 8'hB8, 1'b0, 8'h00);
        chk("R3 clear V", status_byte, 8'hA2);
        cycle(8'h00, 8'h00, 1'b1, 8'h38, 1'b0, 8'h00);
        chk("R4 set C", status_byte, 8'hA3);
        cycle(8'h00, 8'h00, 1'b1, 8'hF8, 1'b0, 8'h00);
        chk("R4 set D", status_byte, 8'hAB);
        cycle(8'h00, 8'h00, 1'b1, 8'h78, 1'b0, 8'h00);
        chk("R4 set I", status_byte, 8'hAF);
        cycle(8'h00, 8'h00, 1'b1, 8'h58, 1'b0, 8'h00);
        cycle(8'h00, 8'h00, 1'b1, 8'h00, 1'b0, 8'h00);
        chk("R4 software interrupt sets I", status_byte, 8'hAF);
    endtask

    task automatic t_priority();
        load(8'h00);
        chk("R6 restore zeros", status_byte, 8'h20);
        cycle(8'hFF, 8'hFF, 1'b1, 8'h18, 1'b0, 8'h00);
        chk("R5 clear C beats ALU, others written", status_byte, 8'hEE);
        load(8'h00);
        cycle(8'h00, 8'h04, 1'b1, 8'h78, 1'b0, 8'h00);
        chk("R5 set I beats ALU", status_byte, 8'h24);
        cycle(8'hFF, 8'hFF, 1'b1, 8'h38, 1'b1, 8'h00);
        chk("R6 restore beats ALU and command", status_byte, 8'h20);
        load(8'hFF);
        chk("R6 restore ones, bit 4 ignored", status_byte, 8'hEF);
        load(8'h30);
        chk("R6 restore bits 5/4 ignored", status_byte, 8'h20);
    endtask

    task automatic t_push();
        load(8'h81);
        @(negedge clk);
        op_valid = 1'b1; op_code = 8'h08;
        #1;
        chk("R7 push shows break bit", status_byte, 8'hB1);
        @(negedge clk);
        idle();
        #1;
        chk("R7 push changes no flag", status_byte, 8'hA1);
        @(negedge clk);
        op_valid = 1'b1; op_code = 8'h00;
        #1;
        chk("R7 software interrupt shows break bit", status_byte, 8'hB1);
        @(negedge clk);
        idle();
        #1;
        chk("R7 break bit drops when idle", status_byte, 8'hA5);
    endtask

    task automatic t_branches(input logic [7:0] st);
        logic [7:0] ops [8] = '{8'hB0, 8'h90, 8'hF0, 8'hD0, 8'h30, 8'h10, 8'h70, 8'h50};
        load(st);
        foreach (ops[k]) begin
            @(negedge clk);
            op_valid = 1'b1; op_code = ops[k];
            #1;
            chk($sformatf("R8 branch %02h flags %02h", ops[k], st),
                {7'b0, branch_taken}, {7'b0, exp_branch(ops[k], st)});
        end
        @(negedge clk);
        idle();
    endtask

    task automatic t_non_branch();
        logic [7:0] ops [6] = '{8'h00, 8'h08, 8'hEA, 8'hB1, 8'h14, 8'h80};
        load(8'hFF);
        foreach (ops[k]) begin
            @(negedge clk);
            op_valid = 1'b1; op_code = ops[k];
            #1;
            chk($sformatf("R9 non-branch %02h", ops[k]), {7'b0, branch_taken}, 8'h00);
        end
        @(negedge clk);
        op_valid = 1'b0; op_code = 8'hB0;
        #1;
        chk("R9 invalid branch op", {7'b0, branch_taken}, 8'h00);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_alu();
        t_cmds();
        t_priority();
        t_push();
        t_branches(8'h20);
        t_branches(8'hEF);
        t_branches(8'h81);
        t_branches(8'h42);
        t_non_branch();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule